// File: doc/BRIEF.md
# Byte-Bus Converter Host Sequencer

This block sits on the system side of a 10-bit successive-approximation converter that talks over an 8-bit bidirectional bus. The bus has an active-low chip select, separate active-low write and read strobes, a byte-select pin that picks the upper or lower part of the result, and an active-low completion line. A client hands the block a request holding a channel number, a single-ended or pseudo-differential choice, a unipolar or bipolar choice, a 2-bit power/clock setting and an acquisition style. The block builds and writes the control byte, waits for the completion line, reads the two result bytes, and returns one extended 16-bit sample with a one-cycle valid pulse.

Requests use a ready/valid handshake and are held back while a conversion is in progress. For acquisition timed by the host, the block issues two writes separated by a programmable acquisition window. When the pipelined input is high and another request is already waiting as the completion line falls, the block writes the next control byte before reading out the finished result, so the next conversion overlaps the readout. If the completion line never falls, a timeout ends the wait and returns an error result. All strobe widths, the power-up wait and the timeout are counted in system clocks.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset the block keeps `cs_n` high and `req_ready` low for PWRUP_CLKS clocks; the first write begins no earlier than that.
- R2: The control byte written is {power[1:0], acquire-bit, single, unipolar, channel[2:0]} with power in bits 7:6, acquire-bit in bit 5, single (1 = single-ended) in bit 4, unipolar (1 = unipolar) in bit 3 and the channel in bits 2:0; in pseudo-differential use the channel's bit 0 picks the positive member of the even/odd pair and is passed unchanged.
- R3: Every bus access lowers `cs_n` one clock before its strobe falls, holds the strobe low for STROBE_CLKS clocks, keeps `cs_n` low and the written byte driven and unchanged for one clock after `wr_n` rises; `wr_n` and `rd_n` are never low together and never low while `cs_n` is high.
- R4: A result is read as two accesses: first with `hben` = 0 giving result bits 7:0, then with `hben` = 1 whose bus bits 1:0 are result bits 9:8; bus bits 7:2 of that second read are ignored.
- R5: A unipolar result is zero-extended to 16 bits and a bipolar result is sign-extended from result bit 9.
- R6: A request with host-timed acquisition produces two writes with identical bits 4:0, the first with bit 5 = 1 and the second with bit 5 = 0, the second strobe rising exactly ACQ_CLKS + STROBE_CLKS + 3 clocks after the first.
- R7: If `int_n` does not fall within TIMEOUT_CLKS clocks of the start of the wait, `res_valid` pulses with `res_err` = 1 and `res_data` = 0, no read is made, and the block becomes ready again.
- R8: `req_ready` is low while a conversion is pending; a request held valid during that time is accepted once, after the earlier result is read (non-pipelined mode).
- R9: With `pipe_en` high and a request waiting when `int_n` falls, the new control byte is written before the earlier result is read, and each result carries the polarity of its own request.
- R10: `res_valid` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_en | input | 1 | Allow the next write to precede the readout |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_chan | input | 3 | Channel address |
| req_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| req_unipolar | input | 1 | 1 = unipolar, 0 = bipolar |
| req_pwr | input | 2 | Power/clock setting placed in bits 7:6 |
| req_ext_acq | input | 1 | 1 = host-timed acquisition with two writes |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Extended result |
| res_err | output | 1 | Result is a timeout |
| cs_n | output | 1 | Converter chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| hben | output | 1 | Byte select for reads |
| bus_oe | output | 1 | Host drives the data bus |
| bus_out | output | 8 | Byte driven on writes |
| bus_in | input | 8 | Byte returned on reads |
| int_n | input | 1 | Conversion complete, active low |

## Verification
The two events that share a cycle are the fall of the completion line and the acceptance of a waiting request in pipelined mode; the block must choose a write over a read in that very cycle. The bench provokes it by holding a second request valid through the first conversion, then judges the order of bus accesses recorded by its converter model (write, write, read, read, read, read) and the values and polarities of both results. The same held request in non-pipelined mode must instead produce write, read, read, write.

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl #(
  parameter int BUS_W        = 8,
  parameter int RES_W        = 10,
  parameter int OUT_W        = 16,
  parameter int PWRUP_CLKS   = 2000,
  parameter int STROBE_CLKS  = 2,
  parameter int ACQ_CLKS     = 8,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-6:0] req_chan,
  input  logic             req_single,
  input  logic             req_unipolar,
  input  logic [1:0]       req_pwr,
  input  logic             req_ext_acq,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data,
  output logic             res_err,
  output logic             cs_n,
  output logic             wr_n,
  output logic             rd_n,
  output logic             hben,
  output logic             bus_oe,
  output logic [BUS_W-1:0] bus_out,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             int_n
);
  localparam int CH_W = BUS_W - 5;
  localparam int HI_W = RES_W - BUS_W;
  localparam int PAD  = OUT_W - RES_W;
  localparam int M1   = (PWRUP_CLKS > TIMEOUT_CLKS) ? PWRUP_CLKS : TIMEOUT_CLKS;
  localparam int M2   = (ACQ_CLKS > STROBE_CLKS) ? ACQ_CLKS : STROBE_CLKS;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1) < 3 ? 3 : $clog2(CMAX + 1);

  typedef struct packed {
    logic            ext;
    logic [1:0]      pwr;
    logic            single;
    logic            uni;
    logic [CH_W-1:0] chan;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_WRA, ST_ACQ, ST_WRB, ST_WAIT, ST_RDL, ST_RDH
  } st_t;

  st_t             st;
  logic [1:0]      ph;
  logic [CW-1:0]   cnt;
  cfg_t            cur, nxt, wcfg, rq;
  logic            piped;
  logic [1:0]      int_s;
  logic [BUS_W-1:0] lo;
  logic [HI_W-1:0] hi;

  wire is_wr      = (st == ST_WRA) || (st == ST_WRB);
  wire is_rd      = (st == ST_RDL) || (st == ST_RDH);
  wire in_bus     = is_wr || is_rd;
  wire strobe_end = (ph == 2'd1) && (cnt == CW'(STROBE_CLKS - 1));
  wire bus_done   = in_bus && (ph == 2'd3);
  wire int_seen   = !int_s[1] && (cnt >= CW'(2));

  assign rq   = {req_ext_acq, req_pwr, req_single, req_unipolar, req_chan};
  assign wcfg = piped ? nxt : cur;

  assign req_ready = (st == ST_IDLE) || ((st == ST_WAIT) && pipe_en && int_seen);
  assign cs_n    = !(in_bus && (ph != 2'd3));
  assign wr_n    = !(is_wr && (ph == 2'd1));
  assign rd_n    = !(is_rd && (ph == 2'd1));
  assign hben    = (st == ST_RDH);
  assign bus_oe  = is_wr && (ph != 2'd3);
  assign bus_out = {wcfg.pwr, (st == ST_WRA) ? wcfg.ext : 1'b0, wcfg.single, wcfg.uni, wcfg.chan};

  always_ff @(posedge clk) begin
    if (!rst_n) int_s <= 2'b11;
    else        int_s <= {int_s[0], int_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWRUP;
      ph        <= 2'd0;
      cnt       <= '0;
      cur       <= '0;
      nxt       <= '0;
      piped     <= 1'b0;
      lo        <= '0;
      hi        <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (in_bus) begin
        case (ph)
          2'd0: begin
            ph  <= 2'd1;
            cnt <= '0;
          end
          2'd1: begin
            if (strobe_end) begin
              ph <= 2'd2;
              if (st == ST_RDL) lo <= bus_in;
              if (st == ST_RDH) hi <= bus_in[HI_W-1:0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          2'd2: ph <= 2'd3;
          default: begin
            ph  <= 2'd0;
            cnt <= '0;
          end
        endcase
      end
      case (st)
        ST_PWRUP: begin
          if (cnt == CW'(PWRUP_CLKS - 1)) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            cur <= rq;
            st  <= ST_WRA;
            ph  <= 2'd0;
            cnt <= '0;
          end
        end
        ST_WRA: begin
          if (bus_done) begin
            if (piped)         st <= ST_RDL;
            else if (cur.ext)  st <= ST_ACQ;
            else               st <= ST_WAIT;
          end
        end
        ST_ACQ: begin
          if (cnt == CW'(ACQ_CLKS - 1)) begin
            st  <= ST_WRB;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRB: begin
          if (bus_done) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (int_seen) begin
            cnt <= '0;
            if (pipe_en && req_valid) begin
              nxt   <= rq;
              piped <= 1'b1;
              st    <= ST_WRA;
            end else begin
              st <= ST_RDL;
            end
          end else if (cnt == CW'(TIMEOUT_CLKS - 1)) begin
            cnt       <= '0;
            st        <= ST_IDLE;
            res_valid <= 1'b1;
            res_err   <= 1'b1;
            res_data  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RDL: begin
          if (bus_done) st <= ST_RDH;
        end
        ST_RDH: begin
          if (bus_done) begin
            res_valid <= 1'b1;
            res_err   <= 1'b0;
            res_data  <= cur.uni ? {{PAD{1'b0}}, hi, lo} : {{PAD{hi[HI_W-1]}}, hi, lo};
            if (piped) begin
              cur   <= nxt;
              piped <= 1'b0;
              st    <= nxt.ext ? ST_ACQ : ST_WAIT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r1_quiet_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PWRUP) |-> (cs_n && !req_ready));
  a_r3_wr_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  a_r3_rd_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (bus_oe && !cs_n && $stable(bus_out)));
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_data == '0));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/sim_adc_host_ctrl.sv
`timescale 1ns/1ps
module sim_adc_host_ctrl;
  localparam int PUP = 50, STB = 2, ACQ = 8, TMO = 200, CONV = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pipe_en = 1'b0, req_valid = 1'b0, req_ready;
  logic [2:0] req_chan = '0;
  logic req_single = 1'b0, req_unipolar = 1'b0, req_ext_acq = 1'b0;
  logic [1:0] req_pwr = '0;
  logic res_valid, res_err;
  logic [15:0] res_data;
  logic cs_n, wr_n, rd_n, hben, bus_oe;
  logic [7:0] bus_out, bus_in;
  logic int_n_r;

  always #2.5 clk = ~clk;

  adc_host_ctrl #(.PWRUP_CLKS(PUP), .STROBE_CLKS(STB), .ACQ_CLKS(ACQ), .TIMEOUT_CLKS(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_single(req_single), .req_unipolar(req_unipolar), .req_pwr(req_pwr),
    .req_ext_acq(req_ext_acq), .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hben(hben), .bus_oe(bus_oe), .bus_out(bus_out),
    .bus_in(bus_in), .int_n(int_n_r));

  int n_cmp = 0, n_bad = 0;
  int cyc;
  logic [9:0] outv;
  logic [9:0] chan_val [8];
  int conv_cnt;
  logic [2:0] conv_ch;
  logic mute = 1'b0;
  logic prev_wr, prev_rd, prev_cs;
  int viol, slen, last_slen, first_cs_t;
  logic [7:0] stb_byte;
  int ev_kind [128];
  logic [7:0] ev_byte [128];
  int ev_t [128];
  int ev_n;

  assign bus_in = hben ? {6'h2A, outv[9:8]} : outv[7:0];

  always @(posedge clk) begin
    int v;
    v = 0;
    if (!rst_n) begin
      cyc <= 0; int_n_r <= 1'b1; conv_cnt <= 0; conv_ch <= '0; outv <= '0;
      prev_wr <= 1'b1; prev_rd <= 1'b1; prev_cs <= 1'b1;
      viol <= 0; slen <= 0; last_slen <= 0; first_cs_t <= -1; ev_n <= 0; stb_byte <= '0;
    end else begin
      cyc <= cyc + 1;
      prev_wr <= wr_n; prev_rd <= rd_n; prev_cs <= cs_n;
      if (!cs_n && first_cs_t < 0) first_cs_t <= cyc;
      if ((!wr_n || !rd_n) && cs_n) v = v + 1;
      if (!wr_n && !rd_n) v = v + 1;
      if (((prev_wr && !wr_n) || (prev_rd && !rd_n)) && prev_cs) v = v + 1;
      if (!wr_n || !rd_n) slen <= slen + 1;
      else if (!prev_wr || !prev_rd) begin last_slen <= slen; slen <= 0; end
      if (!wr_n) stb_byte <= bus_out;
      if (conv_cnt > 0) begin
        conv_cnt <= conv_cnt - 1;
        if (conv_cnt == 1) begin
          outv <= chan_val[conv_ch];
          if (!mute) int_n_r <= 1'b0;
        end
      end
      if (!prev_wr && wr_n && !cs_n) begin
        if (!bus_oe || bus_out != stb_byte) v = v + 1;
        if (ev_n < 128) begin ev_kind[ev_n] <= 0; ev_byte[ev_n] <= bus_out; ev_t[ev_n] <= cyc; end
        ev_n <= ev_n + 1;
        int_n_r <= 1'b1;
        if (!bus_out[5]) begin conv_cnt <= CONV; conv_ch <= bus_out[2:0]; end
      end
      if (prev_rd && !rd_n && !cs_n) begin
        if (ev_n < 128) begin ev_kind[ev_n] <= hben ? 2 : 1; ev_byte[ev_n] <= 8'h00; ev_t[ev_n] <= cyc; end
        ev_n <= ev_n + 1;
        int_n_r <= 1'b1;
      end
      viol <= viol + v;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [2:0] ch, input logic sgl, input logic uni,
                         input logic [1:0] pwr, input logic ext);
    req_chan = ch; req_single = sgl; req_unipolar = uni; req_pwr = pwr; req_ext_acq = ext;
  endtask

  task automatic send(input logic [2:0] ch, input logic sgl, input logic uni,
                      input logic [1:0] pwr, input logic ext);
    @(negedge clk);
    set_req(ch, sgl, uni, pwr, ext);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_res(output logic [15:0] d, output logic e);
    int n;
    n = 0;
    @(negedge clk);
    while (!res_valid && n < 3000) begin @(negedge clk); n++; end
    d = res_data; e = res_err;
    @(negedge clk);
    chk("R10 valid is one cycle", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic chk_ev(input string tag, input int idx, input int kind, input logic [7:0] b);
    chk({tag, " kind"}, ev_kind[idx], kind);
    if (kind == 0) chk({tag, " byte"}, {24'd0, ev_byte[idx]}, {24'd0, b});
  endtask

  task automatic t_pwrup_basic();
    logic [15:0] d; logic e; int c0, base, bad;
    chan_val[5] = 10'h2C3;
    set_req(3'd5, 1'b1, 1'b1, 2'b11, 1'b0);
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc; base = 0; bad = 0;
    for (int i = 0; i < PUP - 2; i++) begin
      @(negedge clk);
      if (req_ready || !cs_n) bad++;
    end
    chk("R1 no ready or select in power-up", bad, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    get_res(d, e);
    chk("R1 first select delay in range",
        {31'd0, (first_cs_t - c0 >= PUP) && (first_cs_t - c0 <= PUP + 3)}, 32'd1);
    chk("R5 unipolar result", {16'd0, d}, 32'h02C3);
    chk("R7 no error on normal result", {31'd0, e}, 32'd0);
    chk("R2 event count", ev_n - base, 3);
    chk_ev("R2 single-ended write", base, 0, 8'hDD);
    chk_ev("R4 low byte first", base + 1, 1, 8'h00);
    chk_ev("R4 high byte second", base + 2, 2, 8'h00);
    chk("R3 strobe width", last_slen, STB);
  endtask

  task automatic t_bipolar();
    logic [15:0] d; logic e; int base;
    chan_val[3] = 10'h3F0;
    chan_val[2] = 10'h1AB;
    base = ev_n;
    send(3'd3, 1'b0, 1'b0, 2'b10, 1'b0);
    get_res(d, e);
    chk_ev("R2 pseudo-diff odd positive write", base, 0, 8'h83);
    chk("R5 bipolar negative sign-extended", {16'd0, d}, 32'hFFF0);
    base = ev_n;
    send(3'd2, 1'b1, 1'b0, 2'b11, 1'b0);
    get_res(d, e);
    chk_ev("R2 bipolar single-ended write", base, 0, 8'hD2);
    chk("R5 bipolar positive result", {16'd0, d}, 32'h01AB);
  endtask

  task automatic t_ext_acq();
    logic [15:0] d; logic e; int base;
    chan_val[6] = 10'h155;
    base = ev_n;
    send(3'd6, 1'b1, 1'b1, 2'b11, 1'b1);
    get_res(d, e);
    chk("R6 event count", ev_n - base, 4);
    chk_ev("R6 first write acquire bit set", base, 0, 8'hFE);
    chk_ev("R6 second write acquire bit clear", base + 1, 0, 8'hDE);
    chk("R6 spacing of write edges", ev_t[base + 1] - ev_t[base], ACQ + STB + 3);
    chk_ev("R4 read low after writes", base + 2, 1, 8'h00);
    chk("R6 result", {16'd0, d}, 32'h0155);
  endtask

  task automatic t_timeout();
    logic [15:0] d; logic e; int base, t0;
    mute = 1'b1;
    base = ev_n;
    send(3'd1, 1'b1, 1'b1, 2'b11, 1'b0);
    t0 = cyc;
    get_res(d, e);
    chk("R7 error flag", {31'd0, e}, 32'd1);
    chk("R7 zero data", {16'd0, d}, 32'd0);
    chk("R7 waited full window", {31'd0, (cyc - t0) >= TMO}, 32'd1);
    chk("R7 no read made", ev_n - base, 1);
    chk("R7 ready again", {31'd0, req_ready}, 32'd1);
    mute = 1'b0;
  endtask

  task automatic t_backpressure();
    logic [15:0] da, db; logic ea, eb; int base;
    chan_val[7] = 10'h001;
    chan_val[1] = 10'h2AA;
    base = ev_n;
    send(3'd7, 1'b1, 1'b1, 2'b11, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 not ready while converting", {31'd0, req_ready}, 32'd0);
    fork
      send(3'd1, 1'b0, 1'b1, 2'b01, 1'b0);
      get_res(da, ea);
    join
    get_res(db, eb);
    chk("R8 event count", ev_n - base, 6);
    chk_ev("R8 first write", base, 0, 8'hDF);
    chk_ev("R8 read low", base + 1, 1, 8'h00);
    chk_ev("R8 read high", base + 2, 2, 8'h00);
    chk_ev("R8 second write after readout", base + 3, 0, 8'h49);
    chk("R8 first result", {16'd0, da}, 32'h0001);
    chk("R8 second result", {16'd0, db}, 32'h02AA);
  endtask

  task automatic t_pipelined();
    logic [15:0] da, db; logic ea, eb; int base;
    chan_val[0] = 10'h3FF;
    chan_val[4] = 10'h200;
    pipe_en = 1'b1;
    base = ev_n;
    send(3'd0, 1'b1, 1'b1, 2'b11, 1'b0);
    fork
      send(3'd4, 1'b0, 1'b0, 2'b11, 1'b0);
      get_res(da, ea);
    join
    get_res(db, eb);
    chk("R9 event count", ev_n - base, 6);
    chk_ev("R9 first write", base, 0, 8'hD8);
    chk_ev("R9 next write before readout", base + 1, 0, 8'hC4);
    chk_ev("R9 read low of first", base + 2, 1, 8'h00);
    chk_ev("R9 read high of first", base + 3, 2, 8'h00);
    chk_ev("R9 read low of second", base + 4, 1, 8'h00);
    chk("R9 first result unipolar", {16'd0, da}, 32'h03FF);
    chk("R9 second result bipolar", {16'd0, db}, 32'hFE00);
    chk("R9 no error", {30'd0, ea, eb}, 32'd0);
    pipe_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) chan_val[i] = '0;
    t_pwrup_basic();
    t_bipolar();
    t_ext_acq();
    t_timeout();
    t_backpressure();
    t_pipelined();
    repeat (4) @(negedge clk);
    chk("R3 bus protocol violations", viol, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule